// File: doc/BRIEF.md
# Single-Cycle Bus Step Sequencer

This block lets a host stand in for a 6502-style processor and run its bus one cycle at a time, for example so that a memory-emulation controller can reach RAM, ROM and I/O behind a halted CPU. The host pulses `start` with an address, a direction flag, write data and a target select. The block then drives the bus clock, address, R/W, one active-low enable and the data lines through a complete cycle, and returns the read data. Every cycle begins with the bus clock high and ends with it high, so a processor that needs a static clock stays frozen between steps.

A clocked peripheral only finishes an access on a later falling edge of the bus clock. For that case the host sets `fill` with the request. After the main cycle the block then runs one more clock-low/clock-high cycle with no enable asserted, and drives a single-cycle no-op opcode onto the data lines. Each clock phase lasts a number of system clocks chosen per request, never fewer than two. `done` pulses when the sequence ends.

Top module: `bus_stepper`

## Requirements
- R1: `bus_clk` is high after reset and in every cycle where `busy` is low.
- R2: A step has three phases of L system clocks each. In the setup phase `bus_clk` is low and all of `bus_en_n` are high. In the select phase `bus_clk` is low and the chosen enable is low. In the high phase `bus_clk` is high and the chosen enable is still low. The enables go high when the high phase ends. Select encoding: 0 drives `bus_en_n[0]` (RAM), 1 drives `bus_en_n[1]` (ROM), 2 drives `bus_en_n[2]` (I/O).
- R3: `bus_addr` and `bus_rw` (1 = read, 0 = write) take the request values on `start` and keep them after the step ends, until the next accepted `start`.
- R4: `bus_oe` is high, with `bus_dout` equal to the write data, only during the high phase of a write step. Outside the write windows of R4 and R8, `bus_oe` is low.
- R5: On a read, `rdata` holds the value of `bus_din` from the last system clock of the high phase.
- R6: `busy` rises in the cycle after an accepted `start` and stays high through a single cycle of `done`, which follows the last phase. After that cycle both are low.
- R7: A `start` while `busy` is high is ignored. The address, the direction, the phase length and the sequence timing all stay as they were.
- R8: With `fill` set, after the high phase comes a clock-low phase and then a clock-high phase, each of L clocks. All enables are high during both, and `bus_rw` reads 1 from then on. During the filler high phase `bus_oe` is high and `bus_dout` is 0x03. `done` follows the filler high phase.
- R9: L is the `phase_len` value taken at `start`. Values 0 and 1 count as 2.
- R10: A select value of 3 asserts no enable at any point in the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| fill | input | 1 | Append a filler cycle after this step |
| wr | input | 1 | 1 = write, 0 = read |
| sel | input | 2 | Target select: 0 RAM, 1 ROM, 2 I/O, 3 none |
| addr | input | AW | Request address |
| wdata | input | DW | Request write data |
| phase_len | input | LW | System clocks per bus clock phase |
| bus_din | input | DW | Data bus input |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Bus clock |
| bus_addr | output | AW | Bus address |
| bus_rw | output | 1 | Bus read/write, 1 = read |
| bus_en_n | output | 3 | Active-low enables: RAM, ROM, I/O |
| bus_dout | output | DW | Data bus output value |
| bus_oe | output | 1 | Data bus drive enable (low = tri-stated) |

## Verification
The bench uses the default widths: 16-bit address, 8-bit data and a 4-bit phase length. Per request it uses phase lengths of 0, 1, 2 and 3, so the clamp to two clocks and a longer phase are both exercised. With such short phases a whole filler sequence is checked in about a dozen cycles. For reads the bench changes the input data exactly in the last high-phase clock, so a capture one cycle early or late shows up as a wrong value.

// File: rtl/bus_stepper.sv
module bus_stepper #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 4,
  parameter logic [DW-1:0] FILL_OP = 'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fill,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] phase_len,
  input  logic [DW-1:0] bus_din,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_clk,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic [2:0]    bus_en_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);

  localparam logic [LW-1:0] MIN_LEN = LW'(2);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_SEL, S_HIGH, S_FLOW, S_FHIGH, S_DONE
  } st_t;

  st_t           st;
  logic [LW-1:0] cnt, len_q;
  logic          fill_q, wr_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] wdata_q;
  logic          last;
  logic          en_on;

  assign last = (cnt == len_q - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      len_q    <= MIN_LEN;
      fill_q   <= 1'b0;
      wr_q     <= 1'b0;
      sel_q    <= 2'd3;
      wdata_q  <= '0;
      bus_addr <= '0;
      bus_rw   <= 1'b1;
      rdata    <= '0;
    end else begin
      if (st == S_IDLE) begin
        if (start) begin
          st       <= S_SETUP;
          cnt      <= '0;
          len_q    <= (phase_len < MIN_LEN) ? MIN_LEN : phase_len;
          fill_q   <= fill;
          wr_q     <= wr;
          sel_q    <= sel;
          wdata_q  <= wdata;
          bus_addr <= addr;
          bus_rw   <= ~wr;
        end
      end else if (st == S_DONE) begin
        st <= S_IDLE;
      end else if (!last) begin
        cnt <= cnt + LW'(1);
      end else begin
        cnt <= '0;
        case (st)
          S_SETUP: st <= S_SEL;
          S_SEL:   st <= S_HIGH;
          S_HIGH: begin
            if (!wr_q) rdata <= bus_din;
            if (fill_q) begin
              st     <= S_FLOW;
              bus_rw <= 1'b1;
            end else begin
              st <= S_DONE;
            end
          end
          S_FLOW:  st <= S_FHIGH;
          default: st <= S_DONE;
        endcase
      end
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign bus_clk = !(st == S_SETUP || st == S_SEL || st == S_FLOW);
  assign en_on   = (st == S_SEL || st == S_HIGH);

  for (genvar i = 0; i < 3; i++) begin : g_en
    assign bus_en_n[i] = !(en_on && sel_q == 2'(i));
  end

  assign bus_oe   = (st == S_HIGH && wr_q) || (st == S_FHIGH);
  assign bus_dout = (st == S_FHIGH) ? FILL_OP : wdata_q;

endmodule

// File: rtl/bus_stepper_chk.sv
module bus_stepper_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          bus_clk,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rw,
  input logic [2:0]    bus_en_n,
  input logic          bus_oe
);

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_clk); // R1

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_en_n) <= 1); // R2

  AST_EN_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_n != 3'b111) |-> (busy && !done)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(bus_addr) && $stable(bus_rw))); // R3

  AST_OE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_clk && busy)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R6

  AST_BUSY_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R7

endmodule

bind bus_stepper bus_stepper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_rw(bus_rw),
  .bus_en_n(bus_en_n), .bus_oe(bus_oe)
);

// File: tb/tb_bus_stepper.sv
module tb_bus_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, fill = 1'b0, wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, bus_din = '0;
  logic [3:0]  phase_len = 4'd2;
  logic        busy, done, bus_clk, bus_rw, bus_oe;
  logic [7:0]  rdata, bus_dout;
  logic [15:0] bus_addr;
  logic [2:0]  bus_en_n;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus_stepper dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fill(fill), .wr(wr), .sel(sel),
    .addr(addr), .wdata(wdata), .phase_len(phase_len), .bus_din(bus_din),
    .busy(busy), .done(done), .rdata(rdata), .bus_clk(bus_clk),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_en_n(bus_en_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  task automatic check_idle(input logic [15:0] a, input logic rw);
    check(bus_clk === 1'b1, "R1", "idle clk", bus_clk, 1);
    check(busy === 1'b0 && done === 1'b0, "R6", "idle busy/done", {busy, done}, 0);
    check(bus_addr === a, "R3", "held addr", bus_addr, a);
    check(bus_rw === rw, "R3", "held rw", bus_rw, rw);
    check(bus_en_n === 3'b111 && bus_oe === 1'b0, "R2", "idle en/oe", {bus_en_n, bus_oe}, 4'he);
  endtask

  // phases: 0 setup, 1 select, 2 high, 3 filler low, 4 filler high
  task automatic run_step(input logic [15:0] a, input logic w, input logic [7:0] wd,
                          input logic [1:0] s, input logic f, input logic [3:0] pl,
                          input bit poke_start);
    int L, nph, n, ph;
    logic [7:0] d1, d2;
    logic       e_clk, e_oe, e_busy, e_done, e_rw;
    logic [2:0] e_en;
    logic [7:0] e_dout;
    L   = (pl < 2) ? 2 : int'(pl);
    nph = f ? 5 : 3;
    n   = nph * L + 1;
    d1  = wd ^ 8'h5a;
    d2  = wd ^ 8'ha5;
    @(negedge clk);
    addr = a; wr = w; wdata = wd; sel = s; fill = f; phase_len = pl;
    bus_din = d1; start = 1'b1;
    for (int k = 1; k <= n + 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke_start && k == 2) begin
        start = 1'b1; addr = ~a; wr = ~w; phase_len = 4'd7; fill = ~f;
      end
      if (k == 3 * L) bus_din = d2;
      ph = (k - 1) / L;
      if (k > n) begin
        check_idle(a, f ? 1'b1 : ~w);
      end else begin
        e_done = (k == n);
        e_busy = 1'b1;
        e_clk  = !(ph == 0 || ph == 1 || ph == 3) || e_done;
        e_en   = 3'b111;
        if (!e_done && (ph == 1 || ph == 2) && s != 2'd3) e_en[s] = 1'b0;
        e_oe   = !e_done && ((ph == 2 && w) || ph == 4);
        e_dout = (ph == 4) ? 8'h03 : wd;
        e_rw   = (f && (ph >= 3)) ? 1'b1 : ~w;
        check(bus_clk === e_clk, f && ph >= 3 && !e_done ? "R8" : "R2", "bus_clk", bus_clk, e_clk);
        check(bus_en_n === e_en, s == 2'd3 ? "R10" : "R2", "bus_en_n", bus_en_n, e_en);
        check(bus_oe === e_oe, ph == 4 ? "R8" : "R4", "bus_oe", bus_oe, e_oe);
        if (e_oe) check(bus_dout === e_dout, ph == 4 ? "R8" : "R4", "bus_dout", bus_dout, e_dout);
        check(busy === e_busy && done === e_done, poke_start ? "R7" : "R6", "busy/done",
              {busy, done}, {e_busy, e_done});
        check(bus_addr === a && bus_rw === e_rw, poke_start ? "R7" : "R3", "addr/rw",
              {bus_addr, bus_rw}, {a, e_rw});
      end
    end
    if (!w) check(rdata === d2, "R5", "rdata", rdata, d2);
  endtask

  task automatic t_reset();
    check(bus_clk === 1'b1, "R1", "reset clk", bus_clk, 1);
    check(busy === 1'b0 && done === 1'b0, "R6", "reset busy/done", {busy, done}, 0);
    check(bus_en_n === 3'b111 && bus_oe === 1'b0, "R4", "reset en/oe", {bus_en_n, bus_oe}, 4'he);
  endtask

  task automatic t_ram_write();   run_step(16'h1234, 1'b1, 8'hc3, 2'd0, 1'b0, 4'd2, 1'b0); endtask
  task automatic t_rom_read();    run_step(16'hfffc, 1'b0, 8'h00, 2'd1, 1'b0, 4'd3, 1'b0); endtask
  task automatic t_io_fill();     run_step(16'ha001, 1'b1, 8'h17, 2'd2, 1'b1, 4'd2, 1'b0); endtask
  task automatic t_io_read_fill();run_step(16'ha000, 1'b0, 8'h3c, 2'd2, 1'b1, 4'd3, 1'b0); endtask
  task automatic t_len_zero();    run_step(16'h0200, 1'b0, 8'h99, 2'd0, 1'b0, 4'd0, 1'b0); endtask // R9
  task automatic t_len_one();     run_step(16'h0201, 1'b1, 8'h42, 2'd1, 1'b0, 4'd1, 1'b0); endtask // R9
  task automatic t_no_sel();      run_step(16'h8000, 1'b1, 8'he1, 2'd3, 1'b0, 4'd2, 1'b0); endtask // R10
  task automatic t_ignore();      run_step(16'h4455, 1'b0, 8'h66, 2'd2, 1'b0, 4'd3, 1'b1); endtask // R7

  initial begin
    #2_000_000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_write();
    t_rom_read();
    t_io_fill();
    t_io_read_fill();
    t_len_zero();
    t_len_one();
    t_no_sel();
    t_ignore();
    repeat (4) begin
      @(negedge clk);
      check_idle(16'h4455, 1'b1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule